// File: doc/BRIEF.md
# Streaming Frame Min-Max Normalizer

The block rescales whole image frames so that the darkest pixel of each frame becomes 0 and the brightest becomes full scale. Signed fixed-point pixels arrive one per clock in raster order over a valid/ready stream, with a flag on the first pixel of every square frame. The block writes each accepted pixel into an on-chip frame store and tracks the running frame minimum and maximum as it goes. Because the extremes are only final after the last pixel, a frame can be emitted only once it has been captured completely.

Two frame stores alternate. While one holds a finished frame that is being replayed, the other captures the next frame. On replay every pixel passes through a pipelined divider of fixed depth that produces `(x - min) / (max - min)` as a 16-bit unsigned fraction. Output pixels leave on a valid/ready stream with first- and last-pixel markers that travel through the pipeline with the data. One instance serves one image channel. Several channels use several instances.

Back-pressure rules: an input pixel transfers on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` falls only when both stores hold frames that have not yet been fully replayed. An output pixel transfers on a rising edge where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, every output holds its value and the whole replay pipeline stalls.

Top module: `minmax_norm`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: Capture of a frame starts only on an accepted pixel with `in_sof` = 1. Pixels accepted while no frame is open are discarded and produce no output.
- R3: An accepted pixel with `in_sof` = 1 in the middle of a frame abandons the partial frame. Capture restarts with that pixel as pixel 0, and the abandoned pixels do not affect any extreme.
- R4: Minimum and maximum are taken over all FRAME_DIM×FRAME_DIM pixels of the frame as signed values. They are seeded from the frame's first pixel.
- R5: Each output equals min(floor((x − min)·65536 / (max − min)), 65535). The frame minimum therefore maps to 0 and the frame maximum to 65535.
- R6: When max equals min, every output pixel of that frame is 0.
- R7: Output pixels of a frame leave in the order they arrived. `out_first` is 1 only on pixel 0 and `out_last` is 1 only on pixel FRAME_DIM²−1. No other outputs appear.
- R8: While `out_valid` = 1 and `out_ready` = 0, the output data and markers stay stable and no pixel is lost or repeated.
- R9: A new frame is captured while the previous one replays. `in_ready` goes low only when both stores hold unreplayed frames.
- R10: Negative pixels, and ranges up to the full signed span of PIX_W bits, normalize correctly.
- R11: With `out_ready` held at 1, back-to-back frames are accepted at one pixel per clock with `in_ready` never low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pixel present |
| in_ready | output | 1 | Block can take an input pixel |
| in_data | input | PIX_W | Signed fixed-point input pixel |
| in_sof | input | 1 | Input pixel is the first of a frame |
| out_valid | output | 1 | Normalized pixel present |
| out_ready | input | 1 | Consumer takes the normalized pixel |
| out_data | output | FRAC_W | Unsigned fraction of full scale |
| out_first | output | 1 | Output pixel is pixel 0 of its frame |
| out_last | output | 1 | Output pixel is the final pixel of its frame |

## Verification
The bench uses a small 8×8 configuration and sweeps the normalization through several kinds of frame. Rising and falling ramps show that the rank order and the end points 0 and 65535 are right. All-negative frames and frames spanning the full 40-bit signed range expose sign-extension and width errors in the subtraction and division. Constant frames exercise the zero-range path, and pseudo-random frames hit interior quotients where rounding errors would show. Pixels sent with no open frame, and a frame abandoned halfway with extreme values, tell apart correct frame start from stale extremes. Held and randomly toggled `out_ready` separate correct stalling and store hand-over from pixel loss or duplication.

// File: rtl/nrm_pkg.sv
package nrm_pkg;
  typedef struct packed {
    logic first;
    logic last;
    logic zero;
  } nrm_tag_t;
endpackage

// File: rtl/nrm_capture.sv
module nrm_capture #(
  parameter int FRAME_DIM = 32,
  parameter int PIX_W     = 40,
  localparam int PIX      = FRAME_DIM * FRAME_DIM,
  localparam int CW       = $clog2(PIX)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic signed [PIX_W-1:0] in_data,
  input  logic                    in_sof,
  input  logic [1:0]              bank_full,
  output logic                    wr_en,
  output logic [CW:0]             wr_addr,
  output logic [PIX_W-1:0]        wr_data,
  output logic                    done,
  output logic                    done_bank,
  output logic signed [PIX_W-1:0] done_min,
  output logic signed [PIX_W-1:0] done_max
);
  logic                    cap_bank;
  logic [CW-1:0]           cnt;
  logic                    active;
  logic signed [PIX_W-1:0] cur_min, cur_max;
  logic                    acc, take;
  logic [CW-1:0]           idx;
  logic signed [PIX_W-1:0] nmin, nmax;

  assign in_ready = !bank_full[cap_bank];
  assign acc      = in_valid && in_ready;
  assign take     = acc && (in_sof || active);
  assign idx      = in_sof ? '0 : cnt;
  assign nmin     = (in_sof || in_data < cur_min) ? in_data : cur_min;
  assign nmax     = (in_sof || in_data > cur_max) ? in_data : cur_max;

  assign wr_en     = take;
  assign wr_addr   = {cap_bank, idx};
  assign wr_data   = in_data;
  assign done      = take && (idx == CW'(PIX - 1));
  assign done_bank = cap_bank;
  assign done_min  = nmin;
  assign done_max  = nmax;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_bank <= 1'b0;
      cnt      <= '0;
      active   <= 1'b0;
      cur_min  <= '0;
      cur_max  <= '0;
    end else if (take) begin
      cur_min <= nmin;
      cur_max <= nmax;
      if (done) begin
        active   <= 1'b0;
        cnt      <= '0;
        cap_bank <= ~cap_bank;
      end else begin
        active <= 1'b1;
        cnt    <= idx + 1'b1;
      end
    end
  end

  AST_SEED_ON_SOF: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_sof) |=> (cur_min == cur_max)); // R4

  AST_EXTREME_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (cur_min <= cur_max)); // R4
endmodule

// File: rtl/nrm_frame_store.sv
module nrm_frame_store #(
  parameter int DW = 40,
  parameter int AW = 11,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_en) rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/nrm_div_step.sv
module nrm_div_step
  import nrm_pkg::*;
#(
  parameter int RW = 41,
  parameter int OW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          v_i,
  input  nrm_tag_t      tag_i,
  input  logic [RW-1:0] rem_i,
  input  logic [RW-1:0] den_i,
  input  logic [OW-1:0] quo_i,
  output logic          v_o,
  output nrm_tag_t      tag_o,
  output logic [RW-1:0] rem_o,
  output logic [RW-1:0] den_o,
  output logic [OW-1:0] quo_o
);
  logic [RW:0]   dbl, sub;
  logic          ge;
  logic [RW-1:0] rem_n;

  assign dbl   = {rem_i, 1'b0};
  assign ge    = dbl >= {1'b0, den_i};
  assign sub   = dbl - {1'b0, den_i};
  assign rem_n = ge ? sub[RW-1:0] : dbl[RW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_o   <= 1'b0;
      tag_o <= '0;
      rem_o <= '0;
      den_o <= '0;
      quo_o <= '0;
    end else if (adv) begin
      v_o   <= v_i;
      tag_o <= tag_i;
      rem_o <= rem_n;
      den_o <= den_i;
      quo_o <= {quo_i[OW-2:0], ge};
    end
  end

  AST_REM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    v_o |-> (rem_o <= den_o)); // R5
endmodule

// File: rtl/minmax_norm.sv
module minmax_norm
  import nrm_pkg::*;
#(
  parameter int FRAME_DIM = 32,
  parameter int PIX_W     = 40,
  parameter int FRAC_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [PIX_W-1:0]  in_data,
  input  logic              in_sof,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [FRAC_W-1:0] out_data,
  output logic              out_first,
  output logic              out_last
);
  localparam int PIX = FRAME_DIM * FRAME_DIM;
  localparam int CW  = $clog2(PIX);
  localparam int AW  = CW + 1;
  localparam int RW  = PIX_W + 1;

  logic                    wr_en, done, done_bank;
  logic [AW-1:0]           wr_addr;
  logic [PIX_W-1:0]        wr_data, rd_data;
  logic signed [PIX_W-1:0] done_min, done_max;
  logic [1:0]              full;
  logic signed [PIX_W-1:0] ext_min [2];
  logic signed [PIX_W-1:0] ext_max [2];

  nrm_capture #(.FRAME_DIM(FRAME_DIM), .PIX_W(PIX_W)) u_capture (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sof(in_sof), .bank_full(full),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .done(done), .done_bank(done_bank), .done_min(done_min), .done_max(done_max)
  );

  // replay control
  logic          rp_bank, adv, issue, rp_last;
  logic [CW-1:0] rp_cnt;

  assign adv     = !out_valid || out_ready;
  assign issue   = adv && full[rp_bank];
  assign rp_last = (rp_cnt == CW'(PIX - 1));

  nrm_frame_store #(.DW(PIX_W), .AW(AW)) u_store (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(issue), .rd_addr({rp_bank, rp_cnt}), .rd_data(rd_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rp_bank <= 1'b0;
      rp_cnt  <= '0;
    end else if (issue) begin
      if (rp_last) begin
        rp_cnt  <= '0;
        rp_bank <= ~rp_bank;
      end else begin
        rp_cnt <= rp_cnt + 1'b1;
      end
    end
  end

  for (genvar b = 0; b < 2; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        full[b]    <= 1'b0;
        ext_min[b] <= '0;
        ext_max[b] <= '0;
      end else if (done && (done_bank == 1'(b))) begin
        full[b]    <= 1'b1;
        ext_min[b] <= done_min;
        ext_max[b] <= done_max;
      end else if (issue && rp_last && (rp_bank == 1'(b))) begin
        full[b] <= 1'b0;
      end
    end

    AST_BANK_EXTREMES: assert property (@(posedge clk) disable iff (!rst_n)
      full[b] |-> (ext_min[b] <= ext_max[b])); // R4
  end

  // stage aligned with the store read
  logic                    v1;
  nrm_tag_t                tag1;
  logic signed [PIX_W-1:0] min1;
  logic [RW-1:0]           rng1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1   <= 1'b0;
      tag1 <= '0;
      min1 <= '0;
      rng1 <= '0;
    end else if (adv) begin
      v1         <= issue;
      tag1.first <= (rp_cnt == '0);
      tag1.last  <= rp_last;
      tag1.zero  <= 1'b0;
      min1       <= ext_min[rp_bank];
      rng1       <= {ext_max[rp_bank][PIX_W-1], ext_max[rp_bank]}
                  - {ext_min[rp_bank][PIX_W-1], ext_min[rp_bank]};
    end
  end

  // divider chain, one quotient bit per stage
  logic          v_c   [FRAC_W+1];
  nrm_tag_t      tag_c [FRAC_W+1];
  logic [RW-1:0] rem_c [FRAC_W+1];
  logic [RW-1:0] den_c [FRAC_W+1];
  logic [FRAC_W-1:0] quo_c [FRAC_W+1];

  always_comb begin
    v_c[0]         = v1;
    tag_c[0]       = tag1;
    tag_c[0].zero  = (rng1 == '0);
    rem_c[0]       = {rd_data[PIX_W-1], rd_data} - {min1[PIX_W-1], min1};
    den_c[0]       = rng1;
    quo_c[0]       = '0;
  end

  for (genvar i = 0; i < FRAC_W; i++) begin : g_div
    nrm_div_step #(.RW(RW), .OW(FRAC_W)) u_step (
      .clk(clk), .rst_n(rst_n), .adv(adv),
      .v_i(v_c[i]), .tag_i(tag_c[i]), .rem_i(rem_c[i]), .den_i(den_c[i]), .quo_i(quo_c[i]),
      .v_o(v_c[i+1]), .tag_o(tag_c[i+1]), .rem_o(rem_c[i+1]), .den_o(den_c[i+1]),
      .quo_o(quo_c[i+1])
    );
  end

  assign out_valid = v_c[FRAC_W];
  assign out_data  = tag_c[FRAC_W].zero ? '0 : quo_c[FRAC_W];
  assign out_first = tag_c[FRAC_W].first;
  assign out_last  = tag_c[FRAC_W].last;

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)
                                   && $stable(out_first) && $stable(out_last))); // R8

  AST_WRITE_FREE_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !full[wr_addr[AW-1]]); // R9

  AST_MARKERS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_first && out_last)); // R7

  AST_READY_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (full != 2'b11) |-> (in_ready || full[0] || full[1])); // R9
endmodule

// File: tb/minmax_norm_bench.sv
module minmax_norm_bench;
  localparam int DIM = 8;
  localparam int PIX = DIM * DIM;
  localparam int DW  = 40;
  localparam int OW  = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [DW-1:0] in_data = '0;
  logic          in_sof = 1'b0;
  logic          out_valid;
  logic          out_ready;
  logic [OW-1:0] out_data;
  logic          out_first, out_last;

  always #10 clk = ~clk;

  minmax_norm #(.FRAME_DIM(DIM), .PIX_W(DW), .FRAC_W(OW)) u_minmax_norm (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sof(in_sof), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_first(out_first), .out_last(out_last)
  );

  typedef struct {
    longint v;
    bit     f;
    bit     l;
    string  tag;
  } exp_t;

  exp_t   exp_q[$];
  int     n_checks = 0;
  int     n_fails  = 0;
  int     stalls   = 0;
  int     rdy_mode = 1;   // 0 hold low, 1 high, 2 pseudo-random
  logic [15:0] lfsr = 16'hACE1;
  longint fr [PIX];

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic longint sx(input logic [DW-1:0] r);
    return longint'({{(64-DW){r[DW-1]}}, r});
  endfunction

  // output monitor and out_ready driver
  initial begin
    out_ready = 1'b1;
    forever begin
      @(negedge clk);
      lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready = (rdy_mode == 1) || (rdy_mode == 2 && lfsr[0]);
      #2;
      if (rst_n && out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R7 extra output", longint'(out_data), -1);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(longint'(out_data) == e.v, e.tag, longint'(out_data), e.v);
          chk(out_first == e.f, "R7 first marker", longint'(out_first), longint'(e.f));
          chk(out_last == e.l, "R7 last marker", longint'(out_last), longint'(e.l));
        end
      end
    end
  end

  task automatic send_pix(input longint v, input bit sof);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = v[DW-1:0];
    in_sof   = sof;
    forever begin
      #2;
      if (in_ready) break;
      stalls++;
      @(negedge clk);
    end
  endtask

  task automatic idle_in();
    @(negedge clk);
    in_valid = 1'b0;
    in_sof   = 1'b0;
  endtask

  task automatic push_expected(input string tag);
    longint mn, mx, rng, q;
    mn = fr[0];
    mx = fr[0];
    for (int i = 1; i < PIX; i++) begin
      if (fr[i] < mn) mn = fr[i];
      if (fr[i] > mx) mx = fr[i];
    end
    rng = mx - mn;
    for (int i = 0; i < PIX; i++) begin
      exp_t e;
      if (rng == 0) q = 0;
      else begin
        q = ((fr[i] - mn) << 16) / rng;
        if (q > 65535) q = 65535;
      end
      e.v = q; e.f = (i == 0); e.l = (i == PIX - 1); e.tag = tag;
      exp_q.push_back(e);
    end
  endtask

  task automatic send_frame(input string tag);
    push_expected(tag);
    for (int i = 0; i < PIX; i++) send_pix(fr[i], i == 0);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #2;
    chk(out_valid == 1'b0, "R1 out_valid after reset", longint'(out_valid), 0);
    chk(in_ready == 1'b1, "R1 in_ready after reset", longint'(in_ready), 1);

    // Phase A: sweep of frame shapes, output always ready
    rdy_mode = 1;
    stalls = 0;
    for (int i = 0; i < PIX; i++) fr[i] = i * 1000;
    send_frame("R5 rising ramp");
    for (int i = 0; i < PIX; i++) fr[i] = (PIX - i) * 37 + 5;
    send_frame("R5 falling ramp");
    for (int i = 0; i < PIX; i++) fr[i] = -longint'(i * i * 311) - 70000;
    send_frame("R10 negative frame");
    for (int i = 0; i < PIX; i++) fr[i] = -123456;
    send_frame("R6 constant frame");
    for (int i = 0; i < PIX; i++)
      fr[i] = (i % 3 == 0) ? -(longint'(1) << 39) : ((i % 3 == 1) ? (longint'(1) << 39) - 1 : 0);
    send_frame("R10 full signed span");
    for (int k = 0; k < 3; k++) begin
      for (int i = 0; i < PIX; i++) fr[i] = sx({$urandom, $urandom});
      send_frame("R5 random frame");
    end
    for (int i = 0; i < PIX; i++) fr[i] = (i == 17) ? 9 : 8;
    send_frame("R5 two-level frame");
    idle_in();
    drain();
    chk(stalls == 0, "R11 input stalls at full rate", stalls, 0);

    // Phase B: pixels with no open frame are dropped
    for (int i = 0; i < 3; i++) send_pix(longint'(1) << 38, 1'b0);
    idle_in();
    repeat (40) @(negedge clk);
    #2;
    chk(out_valid == 1'b0, "R2 no output from orphan pixels", longint'(out_valid), 0);
    for (int i = 0; i < PIX; i++) fr[i] = 50 + (i % 7) * 3;
    send_frame("R2 frame after orphans");
    idle_in();
    drain();

    // Phase C: mid-frame restart
    for (int i = 0; i < 5; i++) send_pix((i % 2) ? (longint'(1) << 38) : -(longint'(1) << 38), i == 0);
    for (int i = 0; i < PIX; i++) fr[i] = 200 - 3 * i;
    send_frame("R3 restarted frame");
    idle_in();
    drain();

    // Phase D: random back-pressure
    rdy_mode = 2;
    for (int k = 0; k < 4; k++) begin
      for (int i = 0; i < PIX; i++) fr[i] = sx({$urandom, $urandom}) >>> (k * 8);
      send_frame("R8 random back-pressure");
    end
    idle_in();
    drain();

    // Phase E: both stores occupied blocks input
    rdy_mode = 0;
    for (int i = 0; i < PIX; i++) fr[i] = i;
    send_frame("R9 first stored frame");
    for (int i = 0; i < PIX; i++) fr[i] = -i;
    send_frame("R9 second stored frame");
    idle_in();
    repeat (5) @(negedge clk);
    #2;
    chk(in_ready == 1'b0, "R9 in_ready low with both stores full", longint'(in_ready), 0);
    chk(out_valid == 1'b1, "R8 output held while not ready", longint'(out_valid), 1);
    rdy_mode = 2;
    for (int i = 0; i < PIX; i++) fr[i] = (i * 7919) % 1013;
    send_frame("R9 frame after release");
    idle_in();
    drain();
    chk(exp_q.size() == 0, "R7 all frames emitted", exp_q.size(), 0);

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end
endmodule